// File: doc/BRIEF.md
# Masked Content-Addressable Memory Array

This block is a small associative store. It holds a fixed number of words and is searched by value rather than by address. Two registers set up a search. The argument register holds the pattern to look for. The key register chooses which bit positions take part in the comparison. A search strobe compares every stored word against the argument in parallel, and the per-word results are latched into a match vector, one bit per word.

Words are written by slot address. The read side is driven straight from the match vector. It reports whether any word matched and whether more than one word matched. It also returns the index and the contents of the lowest-numbered matching word. A write to any slot makes the match vector stale, so a write clears it.

Top module: `mcam_array`

## Requirements
- R1: After reset, `match_o`, `hit_o`, `multi_o`, `rd_data_o` and `rd_idx_o` are all zero. Every stored word, the argument register and the key register are also zero.
- R2: A cycle with `wr_en_i` high stores `wr_data_i` into the slot selected by `wr_addr_i`. No other slot changes.
- R3: With a key bit of 1, bit position j of a word matches only when the stored bit equals argument bit j. A word matches when every compared position matches.
- R4: A key bit of 0 removes that bit position from the comparison. With an all-zero key, every word matches.
- R5: A search takes effect in the cycle after `search_i` is sampled high. It uses the argument and key contents held before that edge. A new argument or key loaded in the same cycle is used only by later searches.
- R6: With neither `search_i` nor `wr_en_i` high, `match_o` holds its value.
- R7: A write clears `match_o` to all zeros in the next cycle. This also holds when `search_i` is high in the same cycle: the search is discarded.
- R8: While any match bit is set, `hit_o` is 1 and `rd_idx_o` is the lowest set index. `rd_data_o` is the stored word in that slot.
- R9: `multi_o` is 1 exactly when two or more bits of `match_o` are set.
- R10: With no match bit set, `hit_o`, `rd_data_o` and `rd_idx_o` are zero.
- R11: The argument register loads `arg_i` when `arg_ld_i` is high. The key register loads `key_i` when `key_ld_i` is high. Each register holds its value otherwise, and the two load independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Slot written |
| wr_data_i | input | 9 | Word written |
| arg_ld_i | input | 1 | Argument register load |
| arg_i | input | 9 | Search pattern |
| key_ld_i | input | 1 | Key register load |
| key_i | input | 9 | Compare-enable mask, 1 = compare |
| search_i | input | 1 | Search strobe |
| match_o | output | 8 | Per-word match vector |
| hit_o | output | 1 | At least one word matched |
| multi_o | output | 1 | Two or more words matched |
| rd_idx_o | output | 3 | Lowest matching slot |
| rd_data_o | output | 9 | Contents of the lowest matching slot |

## Verification
Two pairs of operations can fall in the same cycle. The first is a write together with a search. Directed cycles raise both strobes at once and expect an all-zero match vector afterwards, even when the pre-write contents would have matched. The random phase also produces such collisions. The second is an argument or key load together with a search. Here the expected vector is computed from the register contents held before the load, and it is compared with what a search on the new contents would give.

// File: rtl/mcam_pkg.sv
package mcam_pkg;
  typedef enum logic [1:0] {
    MV_HOLD  = 2'd0,
    MV_CLEAR = 2'd1,
    MV_LOAD  = 2'd2
  } mv_op_e;
endpackage

// File: rtl/mcam_regs.sv
module mcam_regs #(
  parameter int WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arg_ld_i,
  input  logic [WIDTH-1:0] arg_i,
  input  logic             key_ld_i,
  input  logic [WIDTH-1:0] key_i,
  output logic [WIDTH-1:0] arg_o,
  output logic [WIDTH-1:0] key_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_o <= '0;
      key_o <= '0;
    end else begin
      if (arg_ld_i) arg_o <= arg_i;
      if (key_ld_i) key_o <= key_i;
    end
  end
endmodule

// File: rtl/mcam_word.sv
module mcam_word #(
  parameter int WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] arg_i,
  input  logic [WIDTH-1:0] key_i,
  output logic [WIDTH-1:0] q_o,
  output logic             eq_o
);
  logic [WIDTH-1:0] bit_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  // per-cell: equal bits, or position masked out
  for (genvar j = 0; j < WIDTH; j++) begin : g_cell
    logic same;
    assign same      = (arg_i[j] & q_o[j]) | (~arg_i[j] & ~q_o[j]);
    assign bit_ok[j] = same | ~key_i[j];
  end

  assign eq_o = &bit_ok;
endmodule

// File: rtl/mcam_pick.sv
module mcam_pick #(
  parameter int WORDS = 8,
  parameter int WIDTH = 9,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic [WORDS-1:0]            match_i,
  input  logic [WORDS-1:0][WIDTH-1:0] words_i,
  output logic                        hit_o,
  output logic                        multi_o,
  output logic [AW-1:0]               idx_o,
  output logic [WIDTH-1:0]            data_o
);
  always_comb begin
    idx_o = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = AW'(i);
    end
  end

  assign hit_o   = |match_i;
  assign multi_o = (match_i & (match_i - 1'b1)) != '0;
  assign data_o  = hit_o ? words_i[idx_o] : '0;
endmodule

// File: rtl/mcam_array.sv
module mcam_array #(
  parameter int WORDS = 8,
  parameter int WIDTH = 9,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             arg_ld_i,
  input  logic [WIDTH-1:0] arg_i,
  input  logic             key_ld_i,
  input  logic [WIDTH-1:0] key_i,
  input  logic             search_i,
  output logic [WORDS-1:0] match_o,
  output logic             hit_o,
  output logic             multi_o,
  output logic [AW-1:0]    rd_idx_o,
  output logic [WIDTH-1:0] rd_data_o
);
  import mcam_pkg::*;

  logic [WIDTH-1:0]            arg_q, key_q;
  logic [WORDS-1:0][WIDTH-1:0] words;
  logic [WORDS-1:0]            eq_vec;
  logic [WORDS-1:0]            match_q;
  mv_op_e                      mv_op;

  mcam_regs #(.WIDTH(WIDTH)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arg_ld_i (arg_ld_i),
    .arg_i    (arg_i),
    .key_ld_i (key_ld_i),
    .key_i    (key_i),
    .arg_o    (arg_q),
    .key_o    (key_q)
  );

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic we;
    assign we = wr_en_i && (wr_addr_i == AW'(i));
    mcam_word #(.WIDTH(WIDTH)) i_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we),
      .d_i    (wr_data_i),
      .arg_i  (arg_q),
      .key_i  (key_q),
      .q_o    (words[i]),
      .eq_o   (eq_vec[i])
    );
  end

  // write wins over search: contents change, so any result is stale
  always_comb begin
    if (wr_en_i)       mv_op = MV_CLEAR;
    else if (search_i) mv_op = MV_LOAD;
    else               mv_op = MV_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= '0;
    else begin
      unique case (mv_op)
        MV_CLEAR: match_q <= '0;
        MV_LOAD:  match_q <= eq_vec;
        default:  match_q <= match_q;
      endcase
    end
  end

  mcam_pick #(.WORDS(WORDS), .WIDTH(WIDTH)) i_pick (
    .match_i (match_q),
    .words_i (words),
    .hit_o   (hit_o),
    .multi_o (multi_o),
    .idx_o   (rd_idx_o),
    .data_o  (rd_data_o)
  );

  assign match_o = match_q;
endmodule

// File: rtl/mcam_chk.sv
module mcam_chk #(
  parameter int WORDS = 8,
  parameter int WIDTH = 9,
  localparam int AW   = $clog2(WORDS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             key_ld_i,
  input logic [WIDTH-1:0] key_i,
  input logic             search_i,
  input logic [WORDS-1:0] match_o,
  input logic             hit_o,
  input logic             multi_o,
  input logic [AW-1:0]    rd_idx_o,
  input logic [WIDTH-1:0] rd_data_o
);
  logic key_zero_q;

  // tracks whether the key register holds all zeros
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       key_zero_q <= 1'b1;
    else if (key_ld_i) key_zero_q <= (key_i == '0);
  end

  // R7
  wr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> match_o == '0);

  // R6
  match_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !search_i) |=> $stable(match_o));

  // R4
  all_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (search_i && !wr_en_i && key_zero_q) |=> match_o == {WORDS{1'b1}});

  // R8
  pick_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> match_o[rd_idx_o]);

  // R9
  multi_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> hit_o);

  // R10
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (rd_data_o == '0 && rd_idx_o == '0));
endmodule

bind mcam_array mcam_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .key_ld_i  (key_ld_i),
  .key_i     (key_i),
  .search_i  (search_i),
  .match_o   (match_o),
  .hit_o     (hit_o),
  .multi_o   (multi_o),
  .rd_idx_o  (rd_idx_o),
  .rd_data_o (rd_data_o)
);

// File: tb/test_mcam_array.sv
`timescale 1ns/1ps
module test_mcam_array;
  localparam int WORDS = 8;
  localparam int WIDTH = 9;
  localparam int AW    = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [AW-1:0]    wr_addr_i = '0;
  logic [WIDTH-1:0] wr_data_i = '0;
  logic             arg_ld_i = 1'b0;
  logic [WIDTH-1:0] arg_i = '0;
  logic             key_ld_i = 1'b0;
  logic [WIDTH-1:0] key_i = '0;
  logic             search_i = 1'b0;
  logic [WORDS-1:0] match_o;
  logic             hit_o, multi_o;
  logic [AW-1:0]    rd_idx_o;
  logic [WIDTH-1:0] rd_data_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [WIDTH-1:0] m_mem [WORDS];
  logic [WIDTH-1:0] m_arg, m_key;
  logic [WORDS-1:0] m_match;

  always #5 clk_i = ~clk_i;

  mcam_array #(.WORDS(WORDS), .WIDTH(WIDTH)) i_mcam_array (.*);

  function automatic logic [WORDS-1:0] calc_match(logic [WIDTH-1:0] a, logic [WIDTH-1:0] k);
    logic [WORDS-1:0] v;
    for (int i = 0; i < WORDS; i++) v[i] = ((m_mem[i] ^ a) & k) == '0;
    return v;
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [AW-1:0] ei = '0;
    logic [WIDTH-1:0] ed = '0;
    int cnt = 0;
    for (int i = WORDS - 1; i >= 0; i--) if (m_match[i]) ei = AW'(i);
    for (int i = 0; i < WORDS; i++) if (m_match[i]) cnt++;
    if (cnt != 0) ed = m_mem[ei];
    cmp(req, "match", 32'(match_o), 32'(m_match));
    cmp(req, "hit", 32'(hit_o), 32'(cnt != 0));
    cmp(req, "multi", 32'(multi_o), 32'(cnt > 1));
    cmp(req, "idx", 32'(rd_idx_o), 32'(ei));
    cmp(req, "data", 32'(rd_data_o), 32'(ed));
  endtask

  task automatic step(logic we, logic [AW-1:0] wa, logic [WIDTH-1:0] wd,
                      logic ald, logic [WIDTH-1:0] a,
                      logic kld, logic [WIDTH-1:0] k, logic srch);
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    arg_ld_i = ald; arg_i = a; key_ld_i = kld; key_i = k; search_i = srch;
    @(posedge clk_i);
    if (we)        m_match = '0;
    else if (srch) m_match = calc_match(m_arg, m_key);
    if (we)  m_mem[wa] = wd;
    if (ald) m_arg = a;
    if (kld) m_key = k;
    @(negedge clk_i);
    wr_en_i = 1'b0; arg_ld_i = 1'b0; key_ld_i = 1'b0; search_i = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] wa, logic [WIDTH-1:0] wd);
    step(1'b1, wa, wd, 1'b0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic setup(logic [WIDTH-1:0] a, logic [WIDTH-1:0] k);
    step(1'b0, '0, '0, 1'b1, a, 1'b1, k, 1'b0);
  endtask

  task automatic srch();
    step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b1);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
    m_arg = '0; m_key = '0; m_match = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 outputs after reset
    check_all("R1");
    // R1 stored words and registers zero: full key, zero argument -> all slots hit
    setup('0, '1); check_all("R11");
    srch();        check_all("R1");
    cmp("R1", "all_match", 32'(match_o), 32'hFF);

    // R7 write clears, R2 writes
    wr(3'd2, 9'b100111100); check_all("R7");
    wr(3'd5, 9'b101000011); check_all("R2");
    // R3 compare only top three bits
    setup(9'b101111100, 9'b111000000); check_all("R6");
    srch(); check_all("R3");
    cmp("R3", "slot5_only", 32'(match_o), 32'h20);
    cmp("R8", "lowest_data", 32'(rd_data_o), 32'(9'b101000011));
    // R6 idle hold
    repeat (3) begin step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0); check_all("R6"); end
    // R3 full compare: exact value of slot 2
    setup(9'b100111100, '1); srch(); check_all("R3");
    cmp("R3", "slot2_only", 32'(match_o), 32'h04);
    // R4 key zero: everything matches, R9 multi
    setup(9'b010101010, '0); srch(); check_all("R4");
    cmp("R9", "multi", 32'(multi_o), 32'd1);
    // R5 argument loaded with search: old argument used
    setup(9'b101000011, '1);
    step(1'b0, '0, '0, 1'b1, 9'b100111100, 1'b0, '0, 1'b1); check_all("R5");
    cmp("R5", "old_arg", 32'(match_o), 32'h20);
    srch(); check_all("R5");
    cmp("R5", "new_arg", 32'(match_o), 32'h04);
    // R5 key loaded with search: old key used
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, '0, 1'b1); check_all("R5");
    // R7 write and search in same cycle: search discarded
    step(1'b1, 3'd7, 9'b100111100, 1'b0, '0, 1'b0, '0, 1'b1); check_all("R7");
    cmp("R7", "collide", 32'(match_o), 32'h0);
    // R8 lowest index among several: slots 2 and 7 equal
    setup(9'b100111100, '1); srch(); check_all("R8");
    cmp("R8", "idx", 32'(rd_idx_o), 32'd2);
    // R10 miss
    setup(9'b111111111, '1); srch(); check_all("R10");
    cmp("R10", "hit", 32'(hit_o), 32'd0);
    // R11 key load alone keeps argument
    step(1'b0, '0, '0, 1'b0, '0, 1'b1, 9'b000000001, 1'b0); srch(); check_all("R11");

    for (int n = 0; n < 600; n++) begin
      logic [WIDTH-1:0] d, a, k;
      d = ($urandom % 2) ? {6'h0, 3'($urandom)} : 9'($urandom);
      a = ($urandom % 2) ? {6'h0, 3'($urandom)} : 9'($urandom);
      k = 9'($urandom) & 9'($urandom);
      step(($urandom % 5) == 0, 3'($urandom), d,
           ($urandom % 3) == 0, a, ($urandom % 3) == 0, k,
           ($urandom % 2) == 0);
      check_all("R8");
    end
    done = 1'b1;
    finish_run();
  end
endmodule